// File: doc/BRIEF.md
# Descriptor-Chained Scatter/Gather DMA Engine

This engine moves a byte stream to or from memory without processor help, by following a singly linked chain of buffer descriptors that software has placed in memory. Software hands the engine only the address of the first descriptor and a direction bit. The engine then reads each descriptor itself, moves the bytes, and continues to the descriptor it points to. When the whole operation has finished, it raises a single completion interrupt.

In the receive direction, bytes arriving on the input stream are spread over the chained buffers. Each buffer is filled up to its capacity before the next one is used, so a packet longer than one buffer spans several buffers. Once the engine stops using a buffer, it stores back into that descriptor the number of bytes it placed there. In the transmit direction, the engine reads exactly the byte count given by each descriptor. It merges the contents of all the buffers into one outgoing stream and marks the final byte.

Each descriptor is four 32-bit words at consecutive word addresses: the link to the next descriptor (a zero link ends the chain), the buffer's byte address, the buffer size or byte count, and the length written back on receive. Memory is reached through a single request/acknowledge port with byte enables.

Top module: `chain_dma`

## Requirements
- R1: While reset is active, and after it is released, busy, irq, overflow, mem_req, rx_ready and tx_valid are all 0.
- R2: A start_valid pulse while idle is taken: busy is 1 from the next cycle. The first memory request reads the word at the head address. Descriptor words are then read at offsets 0 (link), 4 (buffer address) and 8 (size).
- R3: A start_valid while busy is ignored and does not disturb the operation in progress. This includes the cycle in which irq is high: after that cycle the engine is idle and issues no memory request.
- R4: On receive (start_dir = 0), byte k of the packet goes to byte address buffer+k of the current buffer. The write uses mem_be = one-hot of address bits [1:0] and the byte replicated on every lane. A buffer is filled to its size before the next descriptor is used.
- R5: On receive, every descriptor the engine used gets, at offset 12, the number of bytes deposited in its buffer, zero-extended to 32 bits.
- R6: On receive, the byte marked rx_last ends the operation. Descriptors further down the chain keep their offset-12 word unchanged, and their buffers stay untouched.
- R7: If on receive the last descriptor (link 0) is full and the packet has not ended, overflow becomes 1. The engine raises irq, stops, and accepts no more bytes. A later accepted start clears overflow.
- R8: On transmit (start_dir = 1), the engine sends exactly the size-field number of bytes of each buffer, in chain order. tx_last is 1 only with the final byte of the descriptor whose link is 0.
- R9: A descriptor whose size is 0 moves no bytes and is skipped. On receive its offset-12 word becomes 0.
- R10: irq is a pulse lasting one cycle, given once per operation. busy is 0 in the cycle after it.
- R11: A memory request stays asserted with the same address and write flag until mem_ack. Memory wait states and output stream stalls lose or duplicate no bytes. tx_data and tx_last hold while tx_valid waits for tx_ready.
- R12: rx_ready and tx_valid are never high together. While idle, mem_req, rx_ready and tx_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_valid | input | 1 | Start request pulse |
| start_head | input | AW | Byte address of the first descriptor |
| start_dir | input | 1 | 0 = receive (scatter), 1 = transmit (gather) |
| busy | output | 1 | Operation in progress |
| overflow | output | 1 | Receive chain ran out before the packet ended |
| irq | output | 1 | Completion pulse, one cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_be | output | DW/8 | Byte enables |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | DW | Read data |
| rx_valid | input | 1 | Input byte valid |
| rx_data | input | 8 | Input byte |
| rx_last | input | 1 | Input byte ends the packet |
| rx_ready | output | 1 | Engine accepts an input byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Output byte ends the stream |
| tx_ready | input | 1 | Sink accepts the output byte |

## Verification
A new start request can land in the same cycle as the completion pulse, when the engine is finishing but has not yet returned to idle. The bench provokes this by raising start_valid in the exact cycle it sees irq high. It judges the outcome by checking that busy is low one cycle later and that no descriptor read follows. A start issued in the middle of a transfer is judged the same way, through an unchanged output byte sequence. Memory wait states also coincide with stream stalls, with mem_ack and tx_ready toggled on different phases. Each case is judged by byte-exact buffer contents and written-back lengths.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RX_WAIT, S_RX_WR, S_WB, S_TX_RD, S_TX_SEND, S_DONE
  } sgd_state_e;

  // word slots inside one descriptor
  localparam logic [1:0] W_LINK = 2'd0;
  localparam logic [1:0] W_BUF  = 2'd1;
  localparam logic [1:0] W_SIZE = 2'd2;
  localparam logic [1:0] W_LEN  = 2'd3;
endpackage

// File: rtl/sgd_lanes.sv
module sgd_lanes #(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0] sel,
  input  logic [7:0]              byte_in,
  input  logic [DW-1:0]           word_in,
  output logic [DW/8-1:0]         be,
  output logic [DW-1:0]           wdata,
  output logic [7:0]              byte_out
);
  localparam int NB = DW / 8;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_lane
      assign be[g]           = (sel == g[$clog2(NB)-1:0]);
      assign wdata[8*g +: 8] = byte_in;
    end
  endgenerate

  always_comb begin
    byte_out = '0;
    for (int i = 0; i < NB; i++) begin
      if (be[i]) byte_out = word_in[8*i +: 8];
    end
  end
endmodule

// File: rtl/sgd_count.sv
module sgd_count #(
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc,
  input  logic [LENW-1:0] limit,
  output logic [LENW-1:0] cnt,
  output logic            at_limit
);
  logic [LENW-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + LENW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign at_limit = (cnt == limit);
endmodule

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
  import sgd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_valid,
  input  logic [AW-1:0]   start_head,
  input  logic            start_dir,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [7:0]      lane_byte,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  input  logic            tx_ready,
  input  logic [LENW-1:0] cnt,
  input  logic            at_limit,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_byte,
  output logic [AW-1:0]   mem_addr,
  output logic [LENW-1:0] size_q,
  output logic            cnt_clr,
  output logic            cnt_inc,
  output logic [7:0]      byte_q,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic            tx_last,
  output logic            busy,
  output logic            irq,
  output logic            overflow
);
  localparam logic [AW-1:0] STRIDE = AW'(DW / 8);

  sgd_state_e      state_q, state_d;
  logic            dir_q, dir_d;
  logic [AW-1:0]   desc_q, desc_d;
  logic [AW-1:0]   link_q, link_d;
  logic [AW-1:0]   buf_q, buf_d;
  logic [LENW-1:0] size_d;
  logic [1:0]      idx_q, idx_d;
  logic [7:0]      byte_d;
  logic            eop_q, eop_d;
  logic            ovf_q, ovf_d;
  logic            chain_end;

  assign chain_end = (link_q == '0);

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    desc_d   = desc_q;
    link_d   = link_q;
    buf_d    = buf_q;
    size_d   = size_q;
    idx_d    = idx_q;
    byte_d   = byte_q;
    eop_d    = eop_q;
    ovf_d    = ovf_q;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_byte = 1'b0;
    mem_addr = desc_q + AW'(idx_q) * STRIDE;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    rx_ready = 1'b0;
    tx_valid = 1'b0;
    tx_last  = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start_valid) begin
          desc_d  = start_head;
          dir_d   = start_dir;
          idx_d   = W_LINK;
          eop_d   = 1'b0;
          ovf_d   = 1'b0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          unique case (idx_q)
            W_LINK:  link_d = AW'(mem_rdata);
            W_BUF:   buf_d  = AW'(mem_rdata);
            default: size_d = mem_rdata[LENW-1:0];
          endcase
          if (idx_q == W_SIZE) begin
            idx_d   = W_LINK;
            cnt_clr = 1'b1;
            state_d = dir_q ? S_TX_RD : S_RX_WAIT;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      S_RX_WAIT: begin
        if (at_limit) begin
          state_d = S_WB;
        end else begin
          rx_ready = 1'b1;
          if (rx_valid) begin
            byte_d  = rx_data;
            eop_d   = rx_last;
            state_d = S_RX_WR;
          end
        end
      end
      S_RX_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_byte = 1'b1;
        mem_addr = buf_q + AW'(cnt);
        if (mem_ack) begin
          cnt_inc = 1'b1;
          state_d = eop_q ? S_WB : S_RX_WAIT;
        end
      end
      S_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = desc_q + AW'(W_LEN) * STRIDE;
        if (mem_ack) begin
          if (eop_q) begin
            state_d = S_DONE;
          end else if (chain_end) begin
            ovf_d   = 1'b1;
            state_d = S_DONE;
          end else begin
            desc_d  = link_q;
            state_d = S_FETCH;
          end
        end
      end
      S_TX_RD: begin
        if (at_limit) begin
          if (chain_end) begin
            state_d = S_DONE;
          end else begin
            desc_d  = link_q;
            state_d = S_FETCH;
          end
        end else begin
          mem_req  = 1'b1;
          mem_byte = 1'b1;
          mem_addr = buf_q + AW'(cnt);
          if (mem_ack) begin
            byte_d  = lane_byte;
            state_d = S_TX_SEND;
          end
        end
      end
      S_TX_SEND: begin
        tx_valid = 1'b1;
        tx_last  = chain_end && ((cnt + LENW'(1)) == size_q);
        if (tx_ready) begin
          cnt_inc = 1'b1;
          state_d = S_TX_RD;
        end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dir_q   <= 1'b0;
      desc_q  <= '0;
      link_q  <= '0;
      buf_q   <= '0;
      size_q  <= '0;
      idx_q   <= W_LINK;
      byte_q  <= '0;
      eop_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      desc_q  <= desc_d;
      link_q  <= link_d;
      buf_q   <= buf_d;
      size_q  <= size_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      eop_q   <= eop_d;
      ovf_q   <= ovf_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign irq      = (state_q == S_DONE);
  assign overflow = ovf_q;
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import sgd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_valid,
  input  logic [AW-1:0]   start_head,
  input  logic            start_dir,
  output logic            busy,
  output logic            overflow,
  output logic            irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready
);
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            mem_byte;
  logic [LENW-1:0] cnt;
  logic [LENW-1:0] size_q;
  logic            at_limit;
  logic            cnt_clr;
  logic            cnt_inc;
  logic [7:0]      byte_q;
  logic [7:0]      lane_byte;
  logic [NB-1:0]   lane_be;
  logic [DW-1:0]   lane_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sgd_ctrl #(.AW(AW), .DW(DW), .LENW(LENW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_valid (start_valid),
    .start_head  (start_head),
    .start_dir   (start_dir),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .lane_byte   (lane_byte),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_last     (rx_last),
    .tx_ready    (tx_ready),
    .cnt         (cnt),
    .at_limit    (at_limit),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_byte    (mem_byte),
    .mem_addr    (mem_addr),
    .size_q      (size_q),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .byte_q      (byte_q),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .tx_last     (tx_last),
    .busy        (busy),
    .irq         (irq),
    .overflow    (overflow)
  );

  sgd_count #(.LENW(LENW)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .limit    (size_q),
    .cnt      (cnt),
    .at_limit (at_limit)
  );

  sgd_lanes #(.DW(DW)) u_lanes (
    .sel      (mem_addr[LB-1:0]),
    .byte_in  (byte_q),
    .word_in  (mem_rdata),
    .be       (lane_be),
    .wdata    (lane_wdata),
    .byte_out (lane_byte)
  );

  assign mem_be    = mem_byte ? lane_be : '1;
  assign mem_wdata = mem_byte ? lane_wdata : DW'(cnt);
  assign tx_data   = byte_q;
endmodule

// File: rtl/sgd_chk.sv
module sgd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_valid,
  input logic          busy,
  input logic          irq,
  input logic          overflow,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq && !busy);

  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start_valid |=> busy);

  a_r3_start_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq && start_valid |=> !busy);

  a_r12_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rx_ready && !tx_valid);

  a_r7_ovf_stop: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !rx_ready);
endmodule

bind chain_dma sgd_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_valid (start_valid),
  .busy        (busy),
  .irq         (irq),
  .overflow    (overflow),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .rx_ready    (rx_ready),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last)
);

// File: tb/chain_dma_bench.sv
`timescale 1ns/1ps
module chain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic [31:0] start_head = '0;
  logic        start_dir = 1'b0;
  logic        busy, overflow, irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;

  logic [31:0] mem [0:255];
  int unsigned cyc = 0;
  bit          slow = 1'b0;
  bit          stall = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          irq_n = 0;
  int          tx_n = 0;
  int          last_n = 0;
  int          last_pos = -1;
  logic [7:0]  tx_buf [0:63];
  bit          seen_first = 1'b0;
  logic [31:0] first_addr = '0;

  always #2.5 clk = ~clk;

  chain_dma u_chain_dma (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_head(start_head),
    .start_dir(start_dir), .busy(busy), .overflow(overflow), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // memory and sink models; pacing signals change only at posedge
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_ack   = mem_req && (!slow || cyc[0]);
  assign mem_rdata = mem[mem_addr[9:2]];
  assign tx_ready  = !stall || cyc[1];

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
  end

  always @(negedge clk) begin
    if (irq) irq_n++;
    if (mem_req && !seen_first) begin
      first_addr = mem_addr;
      seen_first = 1'b1;
    end
    if (tx_valid && tx_ready) begin
      if (tx_n < 64) tx_buf[tx_n] = tx_data;
      if (tx_last) begin
        last_n++;
        last_pos = tx_n;
      end
      tx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  function automatic logic [31:0] mword(input int a);
    return mem[a >> 2];
  endfunction

  task automatic setbyte(input int a, input logic [7:0] v);
    mem[a >> 2][8*(a % 4) +: 8] = v;
  endtask

  task automatic put_desc(input int at, input int link, input int bufa, input int size);
    mem[at >> 2]       = link;
    mem[(at >> 2) + 1] = bufa;
    mem[(at >> 2) + 2] = size;
    mem[(at >> 2) + 3] = 32'hFFFF_FFFF;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? 32'hEEEE_EEEE : 32'h0;
    irq_n = 0; tx_n = 0; last_n = 0; last_pos = -1;
  endtask

  task automatic start_op(input int head, input bit dir);
    @(negedge clk);
    seen_first  = 1'b0;
    start_valid = 1'b1;
    start_head  = head;
    start_dir   = dir;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic rx_send(input int n, input int base, input bit gaps, output int taken);
    taken = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1;
      rx_data  = 8'(base + i);
      rx_last  = (i == n - 1);
      while (!rx_ready && busy) @(negedge clk);
      if (!rx_ready) break;
      taken++;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  // R1
  task automatic t_reset();
    chk(busy == 0 && irq == 0 && overflow == 0, "R1 status idle", {busy, irq, overflow}, 0);
    chk(mem_req == 0 && rx_ready == 0 && tx_valid == 0, "R1 ports quiet",
        {mem_req, rx_ready, tx_valid}, 0);
  endtask

  // R2 R4 R5 R6 R12
  task automatic t_rx_scatter();
    int taken;
    clear_mem();
    slow = 0; stall = 0;
    put_desc('h100, 'h110, 'h201, 5);
    put_desc('h110, 'h120, 'h240, 3);
    put_desc('h120, 0, 'h280, 8);
    put_desc('h130, 0, 'h2A0, 4);
    start_op('h100, 1'b0);
    chk(busy == 1, "R2 busy after start", busy, 1);
    rx_send(10, 'h30, 1'b0, taken);
    wait_idle();
    chk(first_addr == 'h100, "R2 first read at head", first_addr, 'h100);
    chk(taken == 10, "R4 bytes accepted", taken, 10);
    for (int i = 0; i < 5; i++) chk(mbyte('h201 + i) == 8'('h30 + i), "R4 buffer A", mbyte('h201 + i), 'h30 + i);
    for (int i = 0; i < 3; i++) chk(mbyte('h240 + i) == 8'('h35 + i), "R4 buffer B", mbyte('h240 + i), 'h35 + i);
    chk(mbyte('h280) == 8'h38 && mbyte('h281) == 8'h39, "R4 buffer C", mbyte('h281), 'h39);
    chk(mbyte('h200) == 8'hEE && mbyte('h206) == 8'hEE, "R4 neighbours kept", mbyte('h206), 'hEE);
    chk(mbyte('h282) == 8'hEE, "R6 no write past packet end", mbyte('h282), 'hEE);
    chk(mword('h10C) == 5, "R5 length A", mword('h10C), 5);
    chk(mword('h11C) == 3, "R5 length B", mword('h11C), 3);
    chk(mword('h12C) == 2, "R5 length C", mword('h12C), 2);
    chk(mword('h13C) == 32'hFFFF_FFFF, "R6 unreached descriptor", mword('h13C), 32'hFFFF_FFFF);
    chk(irq_n == 1, "R10 one irq", irq_n, 1);
    chk(overflow == 0, "R7 no overflow", overflow, 0);
    chk(tx_n == 0, "R12 no output on receive", tx_n, 0);
  endtask

  // R7
  task automatic t_rx_overflow();
    int taken;
    clear_mem();
    put_desc('h100, 'h110, 'h200, 4);
    put_desc('h110, 0, 'h240, 2);
    start_op('h100, 1'b0);
    rx_send(10, 'h60, 1'b0, taken);
    wait_idle();
    chk(taken == 6, "R7 bytes taken before stop", taken, 6);
    chk(overflow == 1, "R7 overflow set", overflow, 1);
    chk(mword('h10C) == 4 && mword('h11C) == 2, "R7 lengths", mword('h11C), 2);
    chk(mbyte('h241) == 8'h65 && mbyte('h242) == 8'hEE, "R7 last buffer", mbyte('h242), 'hEE);
    chk(irq_n == 1, "R7 irq on stop", irq_n, 1);
    rx_valid = 1'b1;
    @(negedge clk);
    chk(rx_ready == 0 && busy == 0, "R7 stopped", rx_ready, 0);
    rx_valid = 1'b0;
  endtask

  // R9 R5 R11 R7 clear
  task automatic t_rx_zero_slow();
    int taken;
    clear_mem();
    slow = 1;
    put_desc('h140, 'h150, 'h2F0, 0);
    put_desc('h150, 'h160, 'h300, 4);
    put_desc('h160, 0, 'h320, 4);
    start_op('h140, 1'b0);
    chk(overflow == 0, "R7 overflow cleared by start", overflow, 0);
    rx_send(4, 'h50, 1'b1, taken);
    wait_idle();
    chk(mword('h14C) == 0, "R9 zero buffer length", mword('h14C), 0);
    chk(mbyte('h2F0) == 8'hEE, "R9 zero buffer untouched", mbyte('h2F0), 'hEE);
    for (int i = 0; i < 4; i++) chk(mbyte('h300 + i) == 8'('h50 + i), "R11 bytes under waits", mbyte('h300 + i), 'h50 + i);
    chk(mword('h15C) == 4, "R5 exact fit length", mword('h15C), 4);
    chk(mword('h16C) == 32'hFFFF_FFFF && mbyte('h320) == 8'hEE, "R6 next descriptor unused", mword('h16C), 32'hFFFF_FFFF);
    chk(irq_n == 1 && overflow == 0, "R10 exact fit completes", irq_n, 1);
    slow = 0;
  endtask

  task automatic tx_chain();
    clear_mem();
    put_desc('h180, 'h190, 'h203, 3);
    put_desc('h190, 'h1A0, 'h260, 0);
    put_desc('h1A0, 0, 'h2C0, 4);
    for (int i = 0; i < 3; i++) setbyte('h203 + i, 8'('hA0 + i));
    for (int i = 0; i < 4; i++) setbyte('h2C0 + i, 8'('hB0 + i));
    setbyte('h260, 8'h77);
  endtask

  function automatic logic [7:0] tx_exp(input int i);
    return (i < 3) ? 8'('hA0 + i) : 8'('hB0 + i - 3);
  endfunction

  // R8 R9 R11
  task automatic t_tx_gather();
    tx_chain();
    slow = 1; stall = 1;
    start_op('h180, 1'b1);
    wait_idle();
    chk(tx_n == 7, "R8 byte count", tx_n, 7);
    for (int i = 0; i < 7; i++) chk(tx_buf[i] == tx_exp(i), "R8 gathered order", tx_buf[i], tx_exp(i));
    chk(last_n == 1 && last_pos == 6, "R8 last on final byte", last_pos, 6);
    chk(irq_n == 1, "R10 one irq on transmit", irq_n, 1);
    slow = 0; stall = 0;
  endtask

  // R3
  task automatic t_start_busy();
    int t = 0;
    tx_chain();
    put_desc('h1C0, 0, 'h380, 2);
    start_op('h180, 1'b1);
    repeat (4) @(negedge clk);
    start_valid = 1'b1; start_head = 'h1C0; start_dir = 1'b0;
    @(negedge clk);
    start_valid = 1'b0;
    while (!irq && t < 5000) begin
      @(negedge clk);
      t++;
    end
    start_valid = 1'b1; start_head = 'h1C0; start_dir = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy == 0 && mem_req == 0, "R3 start at completion ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 0, "R3 remains idle", busy, 0);
    chk(tx_n == 7, "R3 transfer undisturbed", tx_n, 7);
    for (int i = 0; i < 7; i++) chk(tx_buf[i] == tx_exp(i), "R3 sequence kept", tx_buf[i], tx_exp(i));
    chk(irq_n == 1, "R10 single pulse", irq_n, 1);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rx_scatter();
    t_rx_overflow();
    t_rx_zero_slow();
    t_tx_gather();
    t_start_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0x%0h expected=0x0", busy);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule